// File: doc/BRIEF.md
# Receive Byte FIFO with Overflow Discard and Resync Request

This block buffers received bytes between a serial frame receiver and a processor read port. The receiver pushes one byte per write strobe. The processor pops one byte per read strobe and sees it on a registered data output one cycle later. The block holds up to 19 bytes. It reports its occupancy, a near-full indication at a fixed fill level of 15, and a sticky overflow flag.

When the receiver writes into a full FIFO, that byte is dropped. Every further byte offered while the FIFO stays full is dropped too. For each dropped byte the block raises a one-cycle request telling the receiver to abandon the current frame and hunt for a fresh opening flag. The overflow flag stays set until the flag register that owns it is read. That read is signalled to the block by a clear strobe. Reads of other status registers do not reach this block and do not clear the flag.

Top module: `rx_byte_fifo`

## Requirements
- R1: After a synchronous active-high reset, the count is 0, rdData is 0x00, and nearFull, overflow and resyncReq are all low.
- R2: Bytes leave in the order they were accepted. A read strobe on a non-empty FIFO presents the oldest byte on rdData at the next clock edge. The FIFO accepts 19 bytes before it is full, and count always equals the number of bytes stored.
- R3: nearFull is high exactly when count is 15 or more.
- R4: A write strobe with the count at 19 and no read strobe is discarded: count and stored data are unchanged, and overflow is high after that edge.
- R5: resyncReq is high for exactly the one cycle that follows each discarded write, and low otherwise.
- R6: overflow stays high until a cycle with ovfClear high. It then reads low after that edge, unless a write is discarded in that same cycle, in which case it stays high.
- R7: A read strobe on an empty FIFO leaves rdData and count unchanged.
- R8: A read strobe and a write strobe in the same cycle on a full FIFO are both accepted. count stays 19, overflow is not set and resyncReq stays low.
- R9: A read strobe and a write strobe in the same cycle on an empty FIFO accept only the write. count becomes 1 and rdData is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe from the receiver |
| wrData | input | 8 | Byte to write |
| rdEn | input | 1 | Read strobe from the processor port |
| rdData | output | 8 | Last byte read (registered) |
| ovfClear | input | 1 | Clears the overflow flag (flag register read) |
| count | output | 5 | Number of stored bytes |
| nearFull | output | 1 | High at 15 or more stored bytes |
| overflow | output | 1 | Sticky overflow flag |
| resyncReq | output | 1 | One-cycle request to drop the frame and hunt for a new opening flag |

## Verification
On every cycle, the assertions check that the count stays within bounds and does not move on a discarded write or on an empty read. They also check that a discarded write produces both the resync pulse and the overflow flag, and that overflow holds until it is cleared. Only the bench's scenarios can show data ordering, the exact fill level at which the FIFO becomes full, and the value returned by reads. These scenarios include a fill sweep to 23 writes, a full drain with extra empty reads, same-cycle read and write at both ends, and a long pseudo-random mix compared against a byte-queue model.

// File: rtl/rx_byte_fifo_pkg.sv
package rx_byte_fifo_pkg;
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
    logic reject;
  } fifoStrb_t;
endpackage

// File: rtl/rx_byte_fifo_ctrl.sv
module rx_byte_fifo_ctrl
  import rx_byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 19,
  parameter int THRESH = 15,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          ovfClear,
  output fifoStrb_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] count,
  output logic          nearFull,
  output logic          overflow,
  output logic          resyncReq
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] NEAR_CNT  = CW'(THRESH);

  logic notEmpty, notFull;

  assign notEmpty      = (count != '0);
  assign notFull       = (count != FULL_CNT);
  assign strb.rdAccept = rdEn && notEmpty;
  assign strb.wrAccept = wrEn && (notFull || strb.rdAccept);
  assign strb.reject   = wrEn && !strb.wrAccept;
  assign nearFull      = (count >= NEAR_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrAddr <= '0;
      rdAddr <= '0;
      count  <= '0;
    end else begin
      if (strb.wrAccept) wrAddr <= (wrAddr == LAST_ADDR) ? '0 : wrAddr + 1'b1;
      if (strb.rdAccept) rdAddr <= (rdAddr == LAST_ADDR) ? '0 : rdAddr + 1'b1;
      case ({strb.wrAccept, strb.rdAccept})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      resyncReq <= 1'b0;
    end else begin
      resyncReq <= strb.reject;
      if (strb.reject)  overflow <= 1'b1;
      else if (ovfClear) overflow <= 1'b0;
    end
  end

  // R2: occupancy never exceeds the capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R4: a write into a full FIFO without a read leaves the count alone
  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && wrEn && !rdEn) |=> (count == FULL_CNT && overflow));

  // R5: each dropped write is followed by a resync pulse
  a_r5_resync_pulse: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && wrEn && !rdEn) |=> resyncReq);

  // R6: overflow holds while no clear is seen
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovfClear) |=> overflow);

  // R7: empty read with no write keeps the FIFO empty
  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rdEn && !wrEn) |=> (count == '0));

  // R8: read and write together on a full FIFO keeps it full, no overflow event
  a_r8_full_rw: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && wrEn && rdEn) |=> (count == FULL_CNT && !resyncReq));
endmodule

// File: rtl/rx_byte_fifo_data.sv
module rx_byte_fifo_data
  import rx_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 19,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  fifoStrb_t     strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrAccept) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)                rdData <= '0;
    else if (strb.rdAccept) rdData <= mem[rdAddr];
  end

  // R7: with no accepted read, the output byte does not move
  a_r7_rddata_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.rdAccept |=> $stable(rdData));
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import rx_byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 19,
  parameter int THRESH = 15,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  input  logic          ovfClear,
  output logic [CW-1:0] count,
  output logic          nearFull,
  output logic          overflow,
  output logic          resyncReq
);
  fifoStrb_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;

  rx_byte_fifo_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .ovfClear(ovfClear),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .count(count),
    .nearFull(nearFull), .overflow(overflow), .resyncReq(resyncReq)
  );

  rx_byte_fifo_data #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/rx_byte_fifo_tb.sv
module rx_byte_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, rdEn = 1'b0, ovfClear = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] count;
  logic       nearFull, overflow, resyncReq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // model state
  int  q[$];
  int  mRd = 0;
  bit  mOvf = 0, mRes = 0;

  always #4 clk = ~clk;

  rx_byte_fifo u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .ovfClear(ovfClear), .count(count), .nearFull(nearFull),
    .overflow(overflow), .resyncReq(resyncReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string rdTag);
    chk(count == 5'(q.size()), "R2 count", int'(count), q.size());
    chk(nearFull == (q.size() >= 15), "R3 nearFull", int'(nearFull), int'(q.size() >= 15));
    chk(overflow == mOvf, "R6 overflow", int'(overflow), int'(mOvf));
    chk(resyncReq == mRes, "R5 resyncReq", int'(resyncReq), int'(mRes));
    chk(rdData == 8'(mRd), rdTag, int'(rdData), mRd);
  endtask

  // one clock: drive at negedge, model the edge, check after it
  task automatic step(input bit w, input int d, input bit r, input bit c, input string rdTag);
    bit rOk, wOk;
    @(negedge clk);
    wrEn = w; wrData = 8'(d); rdEn = r; ovfClear = c;
    rOk = r && (q.size() > 0);
    wOk = w && ((q.size() < 19) || rOk);
    @(posedge clk);
    if (rOk) mRd = q.pop_front();
    if (wOk) q.push_back(d & 8'hFF);
    mRes = w && !wOk;
    if (mRes) mOvf = 1;
    else if (c) mOvf = 0;
    #2;
    checkAll(rdTag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 rdData");
    chk(count == 0 && !overflow && !resyncReq && rdData == 0, "R1 reset", int'(count), 0);
    @(negedge clk); rst = 1'b0;

    // R9: read and write together on an empty FIFO
    step(1, 8'h5A, 1, 0, "R9 rdData");
    chk(count == 1, "R9 count", int'(count), 1);
    step(0, 0, 1, 0, "R2 rdData");

    // R7: empty reads leave rdData unchanged
    step(0, 0, 1, 0, "R7 rdData");
    step(0, 0, 1, 0, "R7 rdData");

    // R2/R3/R4/R5: fill sweep past capacity
    for (int i = 0; i < 23; i++) begin
      step(1, 8'h10 + i, 0, 0, "R2 rdData");
      if (i == 14) chk(nearFull, "R3 at15", int'(nearFull), 1);
      if (i == 13) chk(!nearFull, "R3 at14", int'(nearFull), 0);
      if (i >= 19) chk(count == 19 && overflow && resyncReq, "R4 dropped", int'(count), 19);
    end
    // R8: read+write on full
    step(0, 0, 0, 0, "R5 rdData");
    chk(!resyncReq, "R5 pulse ends", int'(resyncReq), 0);
    step(0, 0, 0, 1, "R6 rdData");
    chk(!overflow, "R6 cleared", int'(overflow), 1'b0);
    step(1, 8'hEE, 1, 0, "R8 rdData");
    chk(count == 19 && !overflow && !resyncReq && rdData == 8'h10, "R8 full rw", int'(rdData), 8'h10);
    // R6: clear and overflow in the same cycle, set wins
    step(1, 8'h77, 0, 1, "R6 rdData");
    chk(overflow, "R6 set wins", int'(overflow), 1);
    step(0, 0, 0, 1, "R6 rdData");

    // drain everything and beyond
    for (int i = 0; i < 22; i++) step(0, 0, 1, 0, "R2 drain rdData");
    chk(count == 0, "R7 drained", int'(count), 0);

    // pseudo-random mix against the queue model
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], int'(lfsr[15:8]), lfsr[1] & lfsr[5], lfsr[2] & lfsr[4] & lfsr[6],
           "R2 mix rdData");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule